// File: doc/BRIEF.md
# Framed Dual-Sample Serial Transmitter

This block takes one pair of conversion results, a voltage word and a current word, and sends them out as a self-clocked serial frame. The serial clock comes from the block itself. It is divided down from the master clock by a ratio that a rate-select input chooses at the start of each frame.

A frame begins with a sync pulse that lasts one serial clock period, and the serial clock stays idle during that pulse. After the pulse, 96 serial clock periods carry six 16-bit words, most significant bit first. The voltage word goes first, then the current word, then four zero words. The data line changes on falling serial clock edges, so a receiver samples it on rising edges.

A single-cycle sample-ready strobe copies both words into an internal holding image. The strobe is only accepted while the interface is idle. A busy output shows when a frame is in progress.

Top module: `sample_frame_tx`

## Requirements
- R1: While `rst_n` is low, `ser_clk`, `frame_sync`, `ser_data` and `tx_busy` are all low, including when reset is asserted in the middle of a frame.
- R2: With `rate_fast` low at frame start, the serial clock period is 8 master cycles: 4 cycles low followed by 4 cycles high.
- R3: With `rate_fast` high at frame start, the serial clock period is 4 master cycles: 2 cycles low followed by 2 cycles high.
- R4: `frame_sync` rises on the master clock edge that accepts a strobe. It stays high for exactly one serial clock period of the chosen rate, and `ser_clk` stays low while it is high.
- R5: Between the fall of `frame_sync` and the end of the frame there are exactly 96 rising serial clock edges. Outside a frame, `ser_clk` and `frame_sync` are low.
- R6: The bit seen at rising edge k (k = 0..95) is bit 15-(k mod 16) of word k/16. Word 0 is the voltage sample, word 1 is the current sample, and words 2 to 5 are zero.
- R7: `ser_data` changes only on the master clock edge where `ser_clk` falls or where `frame_sync` falls.
- R8: Both samples are captured on the accepting edge. Later changes on `smp_volt` and `smp_curr` do not alter the frame in progress.
- R9: A strobe that arrives while `tx_busy` is high is ignored and produces no extra frame.
- R10: `rate_fast` is sampled only on the accepting edge. Changing it during a frame does not change that frame's serial clock period.
- R11: `tx_busy` is high from the accepting edge for exactly 97 serial clock periods. A strobe in the first idle cycle afterwards starts a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_fast | input | 1 | Divider select: 0 gives divide by 8, 1 gives divide by 4 |
| smp_valid | input | 1 | Sample-ready strobe |
| smp_volt | input | 16 | Voltage sample, sent as the first word |
| smp_curr | input | 16 | Current sample, sent as the second word |
| ser_clk | output | 1 | Generated serial clock |
| frame_sync | output | 1 | Frame sync pulse, one serial clock period long |
| ser_data | output | 1 | Serial data, updated on falling serial clock edges |
| tx_busy | output | 1 | High while a frame is being sent |

## Verification
Let P be the divider ratio in force. After an accepted strobe, the sync pulse is visible from the next master cycle for P cycles. The first serial clock rise comes P/2 cycles after the sync pulse falls, and each later rise follows P cycles after the one before. Busy drops 97·P cycles after the accepting edge.

The bench keeps a free-running cycle count and samples all outputs on the falling master clock edge. Each interval it measures is compared with the value P fixes for that frame. The driver pushes that P and the 96 expected bits into queues, and the monitor pops them at each sync rise and each serial clock rise.

// File: rtl/sft_pkg.sv
package sft_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_SEND = 2'd2
   } sft_state_t;

   function automatic int unsigned sft_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sft_rate_timer.sv
module sft_rate_timer #(
   parameter int unsigned DIV_SLOW = 8,
   parameter int unsigned DIV_FAST = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic rate_fast,
   input  logic run,
   output logic mid_tick,
   output logic end_tick
);
   localparam int unsigned DIV_MAX = sft_pkg::sft_max(DIV_SLOW, DIV_FAST);
   localparam int unsigned CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
   localparam logic [CNT_W-1:0] SLOW_END = CNT_W'(DIV_SLOW - 1);
   localparam logic [CNT_W-1:0] SLOW_MID = CNT_W'(DIV_SLOW / 2 - 1);
   localparam logic [CNT_W-1:0] FAST_END = CNT_W'(DIV_FAST - 1);
   localparam logic [CNT_W-1:0] FAST_MID = CNT_W'(DIV_FAST / 2 - 1);

   if ((DIV_SLOW < 2) || (DIV_SLOW % 2 != 0)) begin : g_bad_slow
      $error("sft_rate_timer: DIV_SLOW must be even and at least 2");
   end
   if ((DIV_FAST < 2) || (DIV_FAST % 2 != 0)) begin : g_bad_fast
      $error("sft_rate_timer: DIV_FAST must be even and at least 2");
   end

   logic             fast_q;
   logic [CNT_W-1:0] phase;
   logic [CNT_W-1:0] end_val;
   logic [CNT_W-1:0] mid_val;

   // divider choice is frozen at frame start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fast_q <= 1'b0;
      else if (load)
         fast_q <= rate_fast;
   end

   assign end_val = fast_q ? FAST_END : SLOW_END;
   assign mid_val = fast_q ? FAST_MID : SLOW_MID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (load)
         phase <= '0;
      else if (run)
         phase <= (phase == end_val) ? '0 : phase + 1'b1;
   end

   assign mid_tick = run && (phase == mid_val);
   assign end_tick = run && (phase == end_val);

endmodule

// File: rtl/sft_frame_shifter.sv
module sft_frame_shifter #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NUM_WORDS = 6,
   parameter int unsigned NUM_LIVE  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [NUM_LIVE*WORD_W-1:0] live_words,
   input  logic                       shift,
   output logic                       head,
   output logic                       next
);
   localparam int unsigned FRAME_W = WORD_W * NUM_WORDS;
   localparam int unsigned LIVE_W  = NUM_LIVE * WORD_W;

   if (NUM_LIVE > NUM_WORDS) begin : g_bad_live
      $error("sft_frame_shifter: more live words than frame slots");
   end
   if (FRAME_W < 2) begin : g_bad_frame
      $error("sft_frame_shifter: frame must hold at least two bits");
   end

   logic [FRAME_W-1:0] image;
   logic [FRAME_W-1:0] sr;

   // slot 0 sits at the MSB end; slots past the live ones are zero pads
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slot
      localparam int unsigned HI = FRAME_W - 1 - w * WORD_W;
      if (w < NUM_LIVE) begin : g_live
         assign image[HI -: WORD_W] = live_words[LIVE_W - 1 - w * WORD_W -: WORD_W];
      end else begin : g_pad
         assign image[HI -: WORD_W] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= image;
      else if (shift)
         sr <= {sr[FRAME_W-2:0], 1'b0};
   end

   assign head = sr[FRAME_W-1];
   assign next = sr[FRAME_W-2];

endmodule

// File: rtl/sft_frame_ctrl.sv
module sft_frame_ctrl #(
   parameter int unsigned FRAME_BITS = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic mid_tick,
   input  logic end_tick,
   input  logic head,
   input  logic next,
   output logic load,
   output logic run,
   output logic shift,
   output logic sclk,
   output logic fsync,
   output logic sdata,
   output logic busy
);
   import sft_pkg::*;

   localparam int unsigned BIT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

   sft_state_t       state;
   logic [BIT_W-1:0] bit_idx;
   logic             last_bit;

   assign last_bit = (bit_idx == LAST_BIT);
   assign load     = (state == ST_IDLE) && start_req;
   assign run      = (state != ST_IDLE);
   assign busy     = (state != ST_IDLE);
   assign shift    = (state == ST_SEND) && end_tick && !last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         sclk    <= 1'b0;
         fsync   <= 1'b0;
         sdata   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_req) begin
                  state <= ST_SYNC;
                  fsync <= 1'b1;
               end
            end
            ST_SYNC: begin
               if (end_tick) begin
                  state   <= ST_SEND;
                  fsync   <= 1'b0;
                  sdata   <= head;
                  bit_idx <= '0;
               end
            end
            ST_SEND: begin
               if (mid_tick)
                  sclk <= 1'b1;
               if (end_tick) begin
                  sclk <= 1'b0;
                  if (last_bit) begin
                     state <= ST_IDLE;
                     sdata <= 1'b0;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     sdata   <= next;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sample_frame_tx.sv
module sample_frame_tx #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NUM_WORDS = 6,
   parameter int unsigned DIV_SLOW  = 8,
   parameter int unsigned DIV_FAST  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_fast,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_volt,
   input  logic [WORD_W-1:0] smp_curr,
   output logic              ser_clk,
   output logic              frame_sync,
   output logic              ser_data,
   output logic              tx_busy
);
   localparam int unsigned NUM_LIVE   = 2;
   localparam int unsigned FRAME_BITS = WORD_W * NUM_WORDS;

   if (NUM_WORDS < NUM_LIVE) begin : g_bad_words
      $error("sample_frame_tx: frame needs room for both samples");
   end

   logic load, run, shift, mid_tick, end_tick, head, next;

   sft_rate_timer #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_FAST (DIV_FAST)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .rate_fast (rate_fast),
      .run       (run),
      .mid_tick  (mid_tick),
      .end_tick  (end_tick)
   );

   sft_frame_shifter #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .NUM_LIVE  (NUM_LIVE)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .live_words ({smp_volt, smp_curr}),
      .shift      (shift),
      .head       (head),
      .next       (next)
   );

   sft_frame_ctrl #(
      .FRAME_BITS (FRAME_BITS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (smp_valid),
      .mid_tick  (mid_tick),
      .end_tick  (end_tick),
      .head      (head),
      .next      (next),
      .load      (load),
      .run       (run),
      .shift     (shift),
      .sclk      (ser_clk),
      .fsync     (frame_sync),
      .sdata     (ser_data),
      .busy      (tx_busy)
   );

endmodule

// File: rtl/sample_frame_tx_chk.sv
module sample_frame_tx_chk #(
   parameter int unsigned FRAME_BITS = 96
) (
   input logic clk,
   input logic rst_n,
   input logic ser_clk,
   input logic frame_sync,
   input logic ser_data,
   input logic tx_busy
);
   localparam int unsigned RC_W = $clog2(FRAME_BITS + 1) + 1;

   logic            sclk_d;
   logic [RC_W-1:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_d <= ser_clk;
         if (frame_sync)
            rise_cnt <= '0;
         else if (ser_clk && !sclk_d)
            rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R1: outputs quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!ser_clk && !frame_sync && !ser_data && !tx_busy)
            else $error("R1: outputs active during reset");
      end
   end

   // R4: no serial clock during the sync pulse
   a_r4_no_clk_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |-> !ser_clk);

   // R4: a sync pulse only starts from an idle interface
   a_r4_sync_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_sync) |-> !$past(tx_busy));

   // R5: nothing toggles outside a frame
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (!ser_clk && !frame_sync));

   // R5: a finished frame carried the full bit count
   a_r5_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> (rise_cnt == RC_W'(FRAME_BITS)));

   // R7: data moves only with a falling serial clock or the end of sync
   a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> ($fell(ser_clk) || $fell(frame_sync)));

endmodule

bind sample_frame_tx sample_frame_tx_chk #(
   .FRAME_BITS (WORD_W * NUM_WORDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ser_clk    (ser_clk),
   .frame_sync (frame_sync),
   .ser_data   (ser_data),
   .tx_busy    (tx_busy)
);

// File: tb/sample_frame_tx_bench.sv
module sample_frame_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int FRAME_BITS = 96;
   localparam int P_SLOW     = 8;
   localparam int P_FAST     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_fast = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_volt = '0;
   logic [15:0] smp_curr = '0;
   logic        ser_clk, frame_sync, ser_data, tx_busy;

   int     n_checks = 0;
   int     n_fails  = 0;
   longint cyc      = 0;
   longint t0       = 0;
   bit     exp_q[$];
   int     per_q[$];
   int     frames_started = 0;
   int     frames_seen    = 0;

   sample_frame_tx u_sample_frame_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_fast  (rate_fast),
      .smp_valid  (smp_valid),
      .smp_volt   (smp_volt),
      .smp_curr   (smp_curr),
      .ser_clk    (ser_clk),
      .frame_sync (frame_sync),
      .ser_data   (ser_data),
      .tx_busy    (tx_busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: called at a falling clock edge with the interface idle
   task automatic start_frame(input logic [15:0] v, input logic [15:0] c, input bit fast);
      logic [95:0] img;
      img = {v, c, 64'h0};
      smp_volt  = v;
      smp_curr  = c;
      rate_fast = fast;
      smp_valid = 1'b1;
      for (int i = FRAME_BITS - 1; i >= 0; i--) exp_q.push_back(img[i]);
      per_q.push_back(fast ? P_FAST : P_SLOW);
      frames_started++;
      @(negedge clk);
      smp_valid = 1'b0;
      t0 = cyc;
      check(tx_busy == 1'b1, "R11", "busy after accepted strobe", tx_busy, 1);
   endtask

   task automatic wait_idle(input int per, input string req);
      while (tx_busy) @(negedge clk);
      check(cyc - t0 == 97 * per, req, "busy length in cycles", cyc - t0, 97 * per);
   endtask

   // monitor / scoreboard
   bit     sclk_q, fsync_q, sdata_q, busy_q;
   int     cur_per = P_SLOW;
   int     rises   = 0;
   longint last_rise  = 0;
   longint sync_start = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
         per_q.delete();
         frames_seen = 0;
         rises = 0;
         sclk_q = 0; fsync_q = 0; sdata_q = 0; busy_q = 0;
      end else begin
         if (frame_sync && !fsync_q) begin
            frames_seen++;
            if (per_q.size() > 0) cur_per = per_q.pop_front();
            else check(1'b0, "R9", "unexpected frame start", 1, 0);
            rises = 0;
            sync_start = cyc;
         end
         if (!frame_sync && fsync_q)
            check(cyc - sync_start == cur_per, "R4", "sync width", cyc - sync_start, cur_per);
         if (ser_clk && !sclk_q) begin
            bit e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            check(ser_data == e, "R6", "bit value", ser_data, e);
            if (rises > 0)
               check(cyc - last_rise == cur_per, (cur_per == P_FAST) ? "R3" : "R2",
                     "clock period", cyc - last_rise, cur_per);
            rises++;
            last_rise = cyc;
         end
         if (!ser_clk && sclk_q)
            check(cyc - last_rise == cur_per / 2, (cur_per == P_FAST) ? "R3" : "R2",
                  "clock high width", cyc - last_rise, cur_per / 2);
         if (ser_data != sdata_q)
            check((sclk_q && !ser_clk) || (fsync_q && !frame_sync), "R7",
                  "data change off falling edge", 1, 0);
         if (!tx_busy && busy_q)
            check(rises == FRAME_BITS, "R5", "rising edges per frame", rises, FRAME_BITS);
         sclk_q = ser_clk; fsync_q = frame_sync; sdata_q = ser_data; busy_q = tx_busy;
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check({ser_clk, frame_sync, ser_data, tx_busy} == 4'b0, "R1", "outputs in reset",
            {ser_clk, frame_sync, ser_data, tx_busy}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // slow rate, mixed pattern
      start_frame(16'hA5C3, 16'h1E0F, 1'b0);
      wait_idle(P_SLOW, "R2");

      // fast rate, edge-bit pattern
      start_frame(16'h8001, 16'h7FFE, 1'b1);
      wait_idle(P_FAST, "R3");

      // R8, R9, R10: disturb inputs and rate mid-frame, strobe while busy
      start_frame(16'hFFFF, 16'h0000, 1'b0);
      repeat (200) @(negedge clk);
      smp_volt  = 16'h1234;
      smp_curr  = 16'hFEDC;
      rate_fast = 1'b1;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      wait_idle(P_SLOW, "R10");
      repeat (50) @(negedge clk);
      check(frames_seen == frames_started, "R9", "frame count", frames_seen, frames_started);
      check(exp_q.size() == 0, "R8", "leftover expected bits", exp_q.size(), 0);

      // R11: back-to-back frames
      start_frame(16'h0F0F, 16'hF00F, 1'b1);
      wait_idle(P_FAST, "R11");
      start_frame(16'h5555, 16'hAAAA, 1'b0);
      wait_idle(P_SLOW, "R11");

      // R1: reset in the middle of a frame, then recovery
      start_frame(16'h1357, 16'h9BDF, 1'b0);
      repeat (300) @(negedge clk);
      #(CLK_PERIOD/4);
      rst_n = 1'b0;
      #1;
      check({ser_clk, frame_sync, ser_data, tx_busy} == 4'b0, "R1", "outputs after mid-frame reset",
            {ser_clk, frame_sync, ser_data, tx_busy}, 0);
      repeat (2) @(negedge clk);
      frames_started = 0;
      rst_n = 1'b1;
      @(negedge clk);
      start_frame(16'hC001, 16'h3FFC, 1'b1);
      wait_idle(P_FAST, "R6");
      repeat (20) @(negedge clk);
      check(frames_seen == frames_started, "R9", "frames after reset", frames_seen, frames_started);
      check(exp_q.size() == 0, "R6", "leftover expected bits", exp_q.size(), 0);
      finish_run();
   end

endmodule